// File: doc/BRIEF.md
# Receive Loss Counter Pair

This block counts received frames that never reach host memory and reports the totals in one read-only status word. It has two separate counters. The first counts frames lost because no receive buffer was free. The second counts frames dropped because the receive FIFO overflowed. Each counter is driven by its own one-cycle event pulse. The two counters have different widths, and each has a sticky flag that records a wrap past full scale. When software sees a flag set, it adds that counter's full-scale value (2^width) instead of the field value.

The status word is driven all the time from the counter registers. A read strobe marks the cycle in which the host samples the word. In that cycle the host gets the current totals, and at the following clock edge both counters and both flags start a new counting period. There is no data stream here: the event pulses, the read strobe and the status word are plain control and status pins with no handshake.

Field positions follow from the widths. The buffer-loss count sits at bits MISS_W-1:0 and its flag at bit MISS_W. The overflow-loss count starts at bit MISS_W+1 and is OVF_W bits wide, and its flag sits just above it. With the defaults (16 and 11) this gives the count at 15:0, the flag at 16, the count at 27:17 and the flag at 28.

Top module: `rx_miss_ctr_pair`

## Requirements
- R1: After reset the whole status word reads zero.
- R2: A buffer-loss pulse with no read increments the field at bits MISS_W-1:0 (15:0 by default) by one at the next clock edge, unless the field is at its maximum.
- R3: An overflow-loss pulse with no read increments the field at bits MISS_W+OVF_W:MISS_W+1 (27:17 by default) by one at the next clock edge, unless the field is at its maximum.
- R4: A buffer-loss pulse while its field is all ones sets the field to zero and sets the flag at bit MISS_W (16 by default).
- R5: An overflow-loss pulse while its field is all ones sets the field to zero and sets the flag at bit MISS_W+OVF_W+1 (28 by default).
- R6: A set flag stays set through any number of further events until a read.
- R7: When the read strobe is high, the word shows the totals in force before the read, and at the next edge both counters and both flags are zero.
- R8: An event in the same cycle as a read is counted in the new period, so the counter for that event reads one after the edge.
- R9: Pulses on both event inputs in the same cycle increment both counters.
- R10: All bits above the overflow-loss flag (31:29 by default) always read zero.
- R11: With no event and no read, the status word does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_evt | input | 1 | One-cycle pulse: a frame was lost because no buffer was free |
| ovf_evt | input | 1 | One-cycle pulse: a frame was lost because the receive FIFO overflowed |
| rd_stb | input | 1 | Read strobe: the word is sampled now and cleared at the next edge |
| status_word | output | WORD_W (32) | Packed counters and sticky flags |

## Verification
The bench builds the block with MISS_W=3 and OVF_W=2 and leaves the word at 32 bits. With these widths the counters wrap after 8 and 4 events, so every count value, both wraps, both flag states and every mix of event pairing with read spacing can be covered in a few thousand cycles. The bench sweeps all four event combinations against read periods of 1 to 10 cycles, then runs a long pseudo-random stream. It compares every cycle with an arithmetic model. Because the field positions depend on the widths, the shifted layout also shows that the reserved bits above the top flag stay at zero.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

  // Update chosen for one counter in a given cycle
  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_CLEAR = 3'd1,
    ACT_LOAD1 = 3'd2,
    ACT_INC   = 3'd3,
    ACT_WRAP  = 3'd4
  } ctr_act_e;

endpackage

// File: rtl/rmc_wrap_ctr.sv
module rmc_wrap_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         evt,
  output logic [W-1:0] cnt,
  output logic         wrapped
);
  import rmc_pkg::*;

  localparam logic [W-1:0] CNT_MAX = '1;

  ctr_act_e act;

  // A clear takes priority, but an event in the same cycle starts the new period at one
  always_comb begin
    if (clr)
      act = evt ? ACT_LOAD1 : ACT_CLEAR;
    else if (evt)
      act = (cnt == CNT_MAX) ? ACT_WRAP : ACT_INC;
    else
      act = ACT_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      wrapped <= 1'b0;
    end else begin
      case (act)
        ACT_CLEAR: begin
          cnt     <= '0;
          wrapped <= 1'b0;
        end
        ACT_LOAD1: begin
          cnt     <= W'(1);
          wrapped <= 1'b0;
        end
        ACT_INC:   cnt <= cnt + W'(1);
        ACT_WRAP: begin
          cnt     <= '0;
          wrapped <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rmc_word_pack.sv
module rmc_word_pack #(
  parameter int MISS_W = 16,
  parameter int OVF_W  = 11,
  parameter int WORD_W = 32
) (
  input  logic [MISS_W-1:0] miss_cnt,
  input  logic              miss_flag,
  input  logic [OVF_W-1:0]  ovf_cnt,
  input  logic              ovf_flag,
  output logic [WORD_W-1:0] word
);
  localparam int MFLAG_POS = MISS_W;
  localparam int OVF_LSB   = MISS_W + 1;
  localparam int OFLAG_POS = OVF_LSB + OVF_W;

  always_comb begin
    word                        = '0;
    word[MISS_W-1:0]            = miss_cnt;
    word[MFLAG_POS]             = miss_flag;
    word[OVF_LSB +: OVF_W]      = ovf_cnt;
    word[OFLAG_POS]             = ovf_flag;
  end

endmodule

// File: rtl/rx_miss_ctr_pair.sv
module rx_miss_ctr_pair #(
  parameter int MISS_W = 16,
  parameter int OVF_W  = 11,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_evt,
  input  logic              ovf_evt,
  input  logic              rd_stb,
  output logic [WORD_W-1:0] status_word
);
  logic [MISS_W-1:0] miss_cnt;
  logic              miss_flag;
  logic [OVF_W-1:0]  ovf_cnt;
  logic              ovf_flag;

  rmc_wrap_ctr #(.W(MISS_W)) u_miss_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (rd_stb),
    .evt     (miss_evt),
    .cnt     (miss_cnt),
    .wrapped (miss_flag)
  );

  rmc_wrap_ctr #(.W(OVF_W)) u_ovf_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (rd_stb),
    .evt     (ovf_evt),
    .cnt     (ovf_cnt),
    .wrapped (ovf_flag)
  );

  rmc_word_pack #(.MISS_W(MISS_W), .OVF_W(OVF_W), .WORD_W(WORD_W)) u_pack (
    .miss_cnt  (miss_cnt),
    .miss_flag (miss_flag),
    .ovf_cnt   (ovf_cnt),
    .ovf_flag  (ovf_flag),
    .word      (status_word)
  );

endmodule

// File: rtl/rx_miss_ctr_pair_chk.sv
module rx_miss_ctr_pair_chk #(
  parameter int MISS_W = 16,
  parameter int OVF_W  = 11,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_evt,
  input logic              ovf_evt,
  input logic              rd_stb,
  input logic [WORD_W-1:0] status_word
);
  localparam int MFLAG_POS = MISS_W;
  localparam int OVF_LSB   = MISS_W + 1;
  localparam int OFLAG_POS = OVF_LSB + OVF_W;
  localparam logic [MISS_W-1:0] M_MAX = '1;
  localparam logic [OVF_W-1:0]  O_MAX = '1;

  logic [MISS_W-1:0] m_f;
  logic [OVF_W-1:0]  o_f;
  logic              m_fl, o_fl;
  logic [WORD_W-1:0] upper;

  assign m_f   = status_word[MISS_W-1:0];
  assign o_f   = status_word[OVF_LSB +: OVF_W];
  assign m_fl  = status_word[MFLAG_POS];
  assign o_fl  = status_word[OFLAG_POS];
  assign upper = status_word >> (OFLAG_POS + 1);

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> status_word == '0);

  a_r2_miss_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && miss_evt && m_f != M_MAX) |=> m_f == $past(m_f) + MISS_W'(1));

  a_r3_ovf_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && ovf_evt && o_f != O_MAX) |=> o_f == $past(o_f) + OVF_W'(1));

  a_r4_miss_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && miss_evt && m_f == M_MAX) |=> (m_f == '0 && m_fl));

  a_r5_ovf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && ovf_evt && o_f == O_MAX) |=> (o_f == '0 && o_fl));

  a_r6_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && m_fl) |=> m_fl);

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && o_fl) |=> o_fl);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !miss_evt && !ovf_evt) |=> status_word == '0);

  a_r8_read_with_events: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (m_f == MISS_W'($past(miss_evt)) && o_f == OVF_W'($past(ovf_evt))
                && !m_fl && !o_fl));

  a_r9_both_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && miss_evt && ovf_evt && m_f != M_MAX && o_f != O_MAX)
      |=> (m_f == $past(m_f) + MISS_W'(1) && o_f == $past(o_f) + OVF_W'(1)));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    upper == '0);

  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !miss_evt && !ovf_evt) |=> $stable(status_word));

endmodule

bind rx_miss_ctr_pair rx_miss_ctr_pair_chk #(
  .MISS_W(MISS_W), .OVF_W(OVF_W), .WORD_W(WORD_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .miss_evt    (miss_evt),
  .ovf_evt     (ovf_evt),
  .rd_stb      (rd_stb),
  .status_word (status_word)
);

// File: tb/test_rx_miss_ctr_pair.sv
module test_rx_miss_ctr_pair;
  localparam int CLK_P = 10;
  localparam int MW    = 3;
  localparam int OW    = 2;
  localparam int WW    = 32;
  localparam int MFB   = MW;
  localparam int OLSB  = MW + 1;
  localparam int OFB   = MW + 1 + OW;
  localparam int MMAX  = (1 << MW) - 1;
  localparam int OMAX  = (1 << OW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_evt = 1'b0;
  logic ovf_evt = 1'b0;
  logic rd_stb = 1'b0;
  logic [WW-1:0] status_word;

  int vec = 0;
  int bad = 0;
  int em = 0;
  int eo = 0;
  bit emf = 1'b0;
  bit eof = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rx_miss_ctr_pair #(.MISS_W(MW), .OVF_W(OW), .WORD_W(WW)) i_rx_miss_ctr_pair (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_evt    (miss_evt),
    .ovf_evt     (ovf_evt),
    .rd_stb      (rd_stb),
    .status_word (status_word)
  );

  function automatic logic [WW-1:0] exp_word();
    logic [WW-1:0] w;
    w = WW'(em) | (WW'(emf) << MFB) | (WW'(eo) << OLSB) | (WW'(eof) << OFB);
    return w;
  endfunction

  task automatic check(string tag, logic [WW-1:0] exp);
    vec++;
    if (status_word !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, status_word, exp);
    end
  endtask

  function automatic string pick_tag(bit m, bit o, bit r);
    if (r && (m || o)) return "R8";
    if (r)             return "R7";
    if (m && em == MMAX) return "R4";
    if (o && eo == OMAX) return "R5";
    if (m && o)        return "R9";
    if ((m || o) && (emf || eof)) return "R6";
    if (m)             return "R2";
    if (o)             return "R3";
    return "R11";
  endfunction

  // Called at a negative edge; leaves at the next negative edge after checking.
  task automatic step(bit m, bit o, bit r);
    string t;
    t = pick_tag(m, o, r);
    miss_evt = m;
    ovf_evt  = o;
    rd_stb   = r;
    if (r) check("R7 read value", exp_word());
    @(posedge clk);
    if (r) begin
      em = m ? 1 : 0;
      eo = o ? 1 : 0;
      emf = 1'b0;
      eof = 1'b0;
    end else begin
      if (m) begin
        if (em == MMAX) begin em = 0; emf = 1'b1; end
        else em++;
      end
      if (o) begin
        if (eo == OMAX) begin eo = 0; eof = 1'b1; end
        else eo++;
      end
    end
    @(negedge clk);
    miss_evt = 1'b0;
    ovf_evt  = 1'b0;
    rd_stb   = 1'b0;
    check(t, exp_word());
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    check("R1 in reset", '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", '0);

    // R2 and R4: count to wrap, then R6: flag held by more events
    for (int i = 0; i < MMAX + 3; i++) step(1'b1, 1'b0, 1'b0);
    // R3 and R5
    for (int i = 0; i < OMAX + 2; i++) step(1'b0, 1'b1, 1'b0);
    // R11 idle
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0);
    // R7 plain read
    step(1'b0, 1'b0, 1'b1);
    // R9 both together
    for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 1'b0);
    // R8 read with events
    step(1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1);

    // Sweep: every event combination against read periods 1..10
    for (int c = 0; c < 4; c++)
      for (int p = 1; p <= 10; p++)
        for (int i = 0; i < 31; i++)
          step(c[0], c[1], (i % p) == (p - 1));

    // Pseudo-random stream, reads less frequent
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[3], lfsr[7:5] == 3'b111);
    end

    // R10: reserved bits above the top flag
    for (int i = 0; i < OMAX + 2; i++) step(1'b1, 1'b1, 1'b0);
    vec++;
    if ((status_word >> (OFB + 1)) != '0) begin
      bad++;
      $display("FAIL R10: got %h expected %h", status_word >> (OFB + 1), 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule